// File: doc/BRIEF.md
# Circular Instruction Pump Queue

This block holds a circular queue of 26-bit instruction words in front of a single execution slot. Instructions enter at the tail (the insertion point). The word at the head (the execution point) is offered to a downstream executor over a request/done handshake. When the executor reports completion, the queue decides what happens to that word. It may be retired. It may stay in place with its count reduced by one. It may be moved back to the tail. The choice depends on its count field and its requeue bit.

Three control forms are handled inside the block and never reach the executor. A kill removes a run of consecutive head entries. A clog parks itself at the head and stops execution. An unclog releases a parked clog. Kill and unclog act from the input side against whatever sits at the head. Full and empty flags report the occupancy.

Top module: `pump_queue`

## Requirements
- R1: After reset the queue is empty: empty_o=1, full_o=0 and exec_req_o=0. An ordinary instruction presented at the input sees in_ready_o=1.
- R2: The queue holds DEPTH entries and keeps them in arrival order. When it is full, full_o=1 and in_ready_o=0 for any non-control word, so no word is dropped.
- R3: The form is decoded from the top bits. Bit 25=1 is a normal word with requeue bit in bit 24 and count in bits 23:17. Otherwise bits 25:23 decode as follows: 011 literal, 010 kill (count in bits 6:0), 001 clog, 000 unclog. A literal executes once and retires.
- R4: A normal word with the requeue bit clear and count n executes n+1 times in a row at the head. The count field offered to the executor falls by one per completion, and the word retires after the execution with count 0.
- R5: A normal word with the requeue bit set and a nonzero count is removed from the head on completion. It is written to the tail with its count lowered by one, behind everything already queued. With count 0 it retires.
- R6: A count of 127 marks a standing word. Completing it never changes its count and never retires it. It repeats in place, or circulates unchanged if its requeue bit is set.
- R7: A kill is accepted only when the queue is not empty and no earlier kill is pending. Once accepted, it removes one head entry per cycle while the queue is occupied, until n+1 entries with count n are gone. It withdraws any pending execute request and blocks the input until it finishes.
- R8: While a clog is at the head, exec_req_o stays low, however long the wait.
- R9: An unclog is accepted only when a clog is at the head. In the cycle it is accepted, the clog is removed as well.
- R10: Once raised, exec_req_o stays high with a stable exec_instr_o until exec_done_i, unless a kill is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction offered at the insertion point |
| in_ready_o | output | 1 | Offered instruction is taken this cycle |
| in_instr_i | input | 26 | Offered instruction word |
| exec_req_o | output | 1 | Head word awaits execution |
| exec_instr_o | output | 26 | Head word |
| exec_done_i | input | 1 | Executor finished the requested word |
| full_o | output | 1 | All entries occupied |
| empty_o | output | 1 | No entries occupied |

## Verification
A table walks single normal words through the count and requeue combinations: count zero, small counts repeated in place, and small counts requeued. Each vector separates a one-shot retire from a repeat or a requeue by counting executions and checking the count field on each one. Two-word sequences then tell repeat-in-place apart from requeue-to-tail by the order in which the words reappear. Directed cases cover the full queue, partial and complete kills, a kill offered to an empty queue, a standing word, a literal, and clog/unclog with an unclog offered too early.

// File: rtl/pump_pkg.sv
package pump_pkg;
  localparam int INSTR_W = 26;
  localparam int CNT_W   = 7;
  localparam logic [CNT_W-1:0] CNT_STANDING = '1;

  localparam int NORM_BIT = 25;
  localparam int RQ_BIT   = 24;
  localparam int CNT_LSB  = 17;

  typedef enum logic [2:0] {
    K_NORM, K_LIT, K_KILL, K_CLOG, K_UNCLOG
  } kind_e;

  function automatic kind_e kind_of(input logic [INSTR_W-1:0] w);
    if (w[NORM_BIT]) return K_NORM;
    case (w[NORM_BIT-1 -: 2])
      2'b11:   return K_LIT;
      2'b10:   return K_KILL;
      2'b01:   return K_CLOG;
      default: return K_UNCLOG;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] cnt_of(input logic [INSTR_W-1:0] w);
    return w[CNT_LSB +: CNT_W];
  endfunction

  function automatic logic [CNT_W-1:0] kill_cnt_of(input logic [INSTR_W-1:0] w);
    return w[CNT_W-1:0];
  endfunction
endpackage

// File: rtl/pump_ring.sv
module pump_ring #(
  parameter int DEPTH = 8,
  parameter int W     = 26,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pop_i,
  input  logic          wr_head_i,
  input  logic [W-1:0]  head_data_i,
  input  logic          rq_push_i,
  input  logic [W-1:0]  rq_data_i,
  input  logic          in_push_i,
  input  logic [W-1:0]  in_data_i,
  output logic [W-1:0]  head_o,
  output logic [CW-1:0] cnt_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] head_q, tail_q, tail2;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // input lands behind a same-cycle requeue
  assign tail2 = rq_push_i ? nxt(tail_q) : tail_q;

  always_ff @(posedge clk_i) begin
    if (wr_head_i) mem_q[head_q] <= head_data_i;
    if (rq_push_i) mem_q[tail_q] <= rq_data_i;
    if (in_push_i) mem_q[tail2]  <= in_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (pop_i) head_q <= nxt(head_q);
      if (in_push_i) tail_q <= nxt(tail2);
      else if (rq_push_i) tail_q <= nxt(tail_q);
      cnt_q <= cnt_q + CW'(in_push_i) + CW'(rq_push_i) - CW'(pop_i);
    end
  end

  assign head_o  = mem_q[head_q];
  assign cnt_o   = cnt_q;
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);

  p_no_overflow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_push_i |-> (cnt_q < CW'(DEPTH)));
  p_no_underflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q != '0));
endmodule

// File: rtl/pump_kill.sv
module pump_kill #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             occupied_i,
  output logic             busy_o,
  output logic             pop_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  assign pop_o  = busy_q && occupied_i;
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load_i) begin
      busy_q <= 1'b1;
      cnt_q  <= cnt_i;
    end else if (pop_o) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else cnt_q <= cnt_q - 1'b1;
    end
  end

  p_kill_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && occupied_i && !load_i) |=> (!busy_q || cnt_q == $past(cnt_q) - 1'b1));
  p_kill_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_q);
endmodule

// File: rtl/pump_queue.sv
module pump_queue
  import pump_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  output logic               in_ready_o,
  input  logic [INSTR_W-1:0] in_instr_i,
  output logic               exec_req_o,
  output logic [INSTR_W-1:0] exec_instr_o,
  input  logic               exec_done_i,
  output logic               full_o,
  output logic               empty_o
);
  logic [INSTR_W-1:0] head, dec_word;
  logic [CW-1:0]      cnt;
  logic               full, empty;
  kind_e              head_kind, in_kind;
  logic [CNT_W-1:0]   head_cnt;
  logic               head_rq;
  logic               kill_busy, kill_pop, kill_load;
  logic               acc, in_push, unclog_pop;
  logic               fin, fin_pop, fin_wr, fin_rq;

  assign head_kind = kind_of(head);
  assign in_kind   = kind_of(in_instr_i);
  assign head_cnt  = cnt_of(head);
  assign head_rq   = head[RQ_BIT];

  // insertion-point admission
  always_comb begin
    case (in_kind)
      K_KILL:   in_ready_o = !kill_busy && !empty;
      K_UNCLOG: in_ready_o = !kill_busy && !empty && (head_kind == K_CLOG);
      default:  in_ready_o = !kill_busy && !full;
    endcase
  end

  assign acc        = in_valid_i && in_ready_o;
  assign kill_load  = acc && (in_kind == K_KILL);
  assign unclog_pop = acc && (in_kind == K_UNCLOG);
  assign in_push    = acc && (in_kind != K_KILL) && (in_kind != K_UNCLOG);

  assign exec_req_o   = !empty && !kill_busy && (head_kind inside {K_NORM, K_LIT});
  assign exec_instr_o = head;
  assign fin          = exec_req_o && exec_done_i;

  always_comb begin
    dec_word = head;
    dec_word[CNT_LSB +: CNT_W] = head_cnt - 1'b1;
  end

  // completion disposition: retire, repeat in place, or requeue
  always_comb begin
    fin_pop = 1'b0;
    fin_wr  = 1'b0;
    fin_rq  = 1'b0;
    if (fin) begin
      if (head_kind == K_LIT || head_cnt == '0) begin
        fin_pop = 1'b1;
      end else if (head_rq) begin
        fin_pop = 1'b1;
        fin_rq  = 1'b1;
      end else if (head_cnt != CNT_STANDING) begin
        fin_wr = 1'b1;
      end
    end
  end

  pump_kill #(.CNT_W(CNT_W)) u_kill (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (kill_load),
    .cnt_i      (kill_cnt_of(in_instr_i)),
    .occupied_i (!empty),
    .busy_o     (kill_busy),
    .pop_o      (kill_pop)
  );

  pump_ring #(.DEPTH(DEPTH), .W(INSTR_W)) u_ring (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pop_i       (kill_pop || unclog_pop || fin_pop),
    .wr_head_i   (fin_wr),
    .head_data_i (dec_word),
    .rq_push_i   (fin_rq),
    .rq_data_i   ((head_cnt == CNT_STANDING) ? head : dec_word),
    .in_push_i   (in_push),
    .in_data_i   (in_instr_i),
    .head_o      (head),
    .cnt_o       (cnt),
    .full_o      (full),
    .empty_o     (empty)
  );

  assign full_o  = full;
  assign empty_o = empty;

  p_req_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_req_o && !exec_done_i && !kill_load) |=> (exec_req_o && $stable(exec_instr_o)));
  p_unclog_pair_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unclog_pop |=> (cnt == $past(cnt) - 1'b1));
  p_standing_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin && head_kind == K_NORM && head_cnt == CNT_STANDING && !head_rq)
      |=> ($stable(exec_instr_o) && $stable(cnt)));
  p_clog_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!empty && head_kind == K_CLOG && !unclog_pop && !kill_pop) |=> !exec_req_o);
endmodule

// File: tb/pump_queue_tb.sv
`timescale 1ns/100ps
module pump_queue_tb;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid = 1'b0;
  logic [25:0] in_instr = '0;
  logic        exec_done = 1'b0;
  logic        in_ready_o, exec_req_o, full_o, empty_o;
  logic [25:0] exec_instr_o;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  pump_queue #(.DEPTH(DEPTH)) u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .in_valid_i   (in_valid),
    .in_ready_o   (in_ready_o),
    .in_instr_i   (in_instr),
    .exec_req_o   (exec_req_o),
    .exec_instr_o (exec_instr_o),
    .exec_done_i  (exec_done),
    .full_o       (full_o),
    .empty_o      (empty_o)
  );

  // {count[7], rq, expected executions[8]}
  localparam logic [15:0] VEC [5] = '{
    {7'd0, 1'b0, 8'd1},
    {7'd3, 1'b0, 8'd4},
    {7'd2, 1'b1, 8'd3},
    {7'd5, 1'b1, 8'd6},
    {7'd0, 1'b1, 8'd1}
  };

  function automatic logic [25:0] norm(input logic rq, input logic [6:0] c, input logic [16:0] tag);
    return {1'b1, rq, c, tag};
  endfunction
  function automatic logic [25:0] kill(input logic [6:0] c);
    return {3'b010, 16'd0, c};
  endfunction
  localparam logic [25:0] CLOG   = {3'b001, 23'd0};
  localparam logic [25:0] UNCLOG = 26'd0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [25:0] w);
    in_valid = 1'b1;
    in_instr = w;
    #1;
    for (int k = 0; k < 50 && !in_ready_o; k++) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic fire(output logic ok, output logic [25:0] w);
    ok = 1'b0;
    w  = '0;
    for (int k = 0; k < 20 && !ok; k++) begin
      #1;
      if (exec_req_o) begin
        ok = 1'b1;
        w  = exec_instr_o;
      end else @(negedge clk);
    end
    if (ok) begin
      exec_done = 1'b1;
      @(negedge clk);
      exec_done = 1'b0;
    end
  endtask

  task automatic expect_exec(input string req, input logic [16:0] tag, input logic [6:0] c);
    logic ok;
    logic [25:0] w;
    fire(ok, w);
    chk(ok && w[16:0] == tag && w[23:17] == c, req, {6'd0, w}, {8'd0, c, tag});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ok;
    logic [25:0] w;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);

    // R1 reset state
    in_instr = norm(1'b0, 7'd0, 17'h1);
    #1;
    chk(empty_o && !full_o && !exec_req_o && in_ready_o, "R1",
        {empty_o, full_o, exec_req_o, in_ready_o}, 4'b1001);
    @(negedge clk);

    // R4/R5 vector table
    for (int i = 0; i < 5; i++) begin
      logic [6:0] c;
      logic       rq;
      logic [7:0] n;
      c  = VEC[i][15:9];
      rq = VEC[i][8];
      n  = VEC[i][7:0];
      send(norm(rq, c, 17'(i + 'h100)));
      for (int e = 0; e < n; e++)
        expect_exec(rq ? "R5 vec" : "R4 vec", 17'(i + 'h100), c - 7'(e));
      #1;
      chk(empty_o && !exec_req_o, rq ? "R5 retire" : "R4 retire", {31'd0, empty_o}, 1);
      @(negedge clk);
    end

    // R5 requeue goes behind queued work
    send(norm(1'b1, 7'd1, 17'h11));
    send(norm(1'b0, 7'd0, 17'h22));
    expect_exec("R5 order", 17'h11, 7'd1);
    expect_exec("R5 order", 17'h22, 7'd0);
    expect_exec("R5 order", 17'h11, 7'd0);

    // R4 repeat stays at head
    send(norm(1'b0, 7'd1, 17'h33));
    send(norm(1'b0, 7'd0, 17'h22));
    expect_exec("R4 order", 17'h33, 7'd1);
    expect_exec("R4 order", 17'h33, 7'd0);
    expect_exec("R4 order", 17'h22, 7'd0);

    // R3 literal executes once
    send({3'b011, 23'h5a5a});
    fire(ok, w);
    chk(ok && w == {3'b011, 23'h5a5a}, "R3 literal", {6'd0, w}, {9'd0, 23'h5a5a});
    #1;
    chk(empty_o, "R3 literal retire", {31'd0, empty_o}, 1);
    @(negedge clk);

    // R7 kill refused on empty queue
    in_valid = 1'b1;
    in_instr = kill(7'd0);
    #1;
    chk(!in_ready_o, "R7 empty", {31'd0, in_ready_o}, 0);
    @(negedge clk);
    in_valid = 1'b0;

    // R2 fill to capacity
    for (int i = 0; i < DEPTH; i++) send(norm(1'b0, 7'd5, 17'(i)));
    in_valid = 1'b1;
    in_instr = norm(1'b0, 7'd0, 17'h99);
    #1;
    chk(full_o && !in_ready_o, "R2 full", {full_o, in_ready_o}, 2'b10);
    @(negedge clk);
    in_valid = 1'b0;

    // R7 kill count 2 removes three, preempts request
    send(kill(7'd2));
    #1;
    chk(!exec_req_o, "R7 preempt", {31'd0, exec_req_o}, 0);
    repeat (3) @(negedge clk);
    #1;
    chk(exec_req_o && exec_instr_o[16:0] == 17'd3 && !full_o, "R7 partial R2 order",
        {6'd0, exec_instr_o}, 32'd3);
    @(negedge clk);
    send(kill(7'd4));
    repeat (5) @(negedge clk);
    #1;
    chk(empty_o, "R7 drain", {31'd0, empty_o}, 1);
    @(negedge clk);

    // R6 standing
    send(norm(1'b0, 7'd127, 17'h44));
    for (int e = 0; e < 4; e++) expect_exec("R6 standing", 17'h44, 7'd127);
    #1;
    chk(!empty_o, "R6 kept", {31'd0, empty_o}, 0);
    @(negedge clk);
    send(kill(7'd0));
    @(negedge clk);
    #1;
    chk(empty_o, "R7 kill0", {31'd0, empty_o}, 1);
    @(negedge clk);

    // R8/R9 clog and unclog
    send(norm(1'b0, 7'd0, 17'h55));
    send(CLOG);
    send(norm(1'b0, 7'd0, 17'h66));
    in_valid = 1'b1;
    in_instr = UNCLOG;
    #1;
    chk(!in_ready_o, "R9 early", {31'd0, in_ready_o}, 0);
    @(negedge clk);
    in_valid = 1'b0;
    expect_exec("R8 before", 17'h55, 7'd0);
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(!exec_req_o && !empty_o, "R8 stall", {31'd0, exec_req_o}, 0);
      @(negedge clk);
    end
    send(UNCLOG);
    #1;
    chk(exec_req_o && exec_instr_o[16:0] == 17'h66, "R9 release",
        {6'd0, exec_instr_o}, 32'h66);
    expect_exec("R9 after", 17'h66, 7'd0);
    #1;
    chk(empty_o, "R9 empty", {31'd0, empty_o}, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule